// File: doc/BRIEF.md
# 100BASE-X Receive Code-Group Decoder

This block sits behind the symbol aligner of a 100 Mb/s receive path. It takes one aligned 5-bit code group per accepted cycle and produces the nibble-wide receive interface toward a MAC: a data nibble, a data-valid flag, an error flag and a carrier flag. It finds the start of a frame from the start delimiter pair, turns data code groups back into nibbles with the 4B/5B mapping, and closes the frame on the end delimiter pair. It flags bad code groups and carrier events that look like frames but are not.

A frame can only be confirmed once the code group after /J/ is known, and it can only be closed once the code group after /T/ is known. For this reason the decoder keeps one code group in hand. The result for code group k is presented when code group k+1 is accepted. The input side is a stream qualified by `in_valid`, and each accepted code group yields exactly one output strobe on `out_valid` in the next cycle. Between strobes the outputs hold their values. There is no ready signal and no back-pressure: the line delivers code groups at a fixed rate and the MAC side cannot stall. The producer may leave gaps by lowering `in_valid`.

Top module: `rxs_decoder`

## Requirements
- R1: Inside a frame, a data code group gives rx_dv=1, rx_er=0, rx_crs=1 and rxd set to its nibble from the 4B/5B table (0..F map from 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101).
- R2: /J/ (11000) directly followed by /K/ (10001) outside a frame opens a frame. Both are presented as preamble nibbles 0101 with rx_dv=1, rx_er=0 and rx_crs=1, and rx_dv never rises on any other nibble.
- R3: /J/ outside a frame that is not followed by /K/ is a false carrier. It gives rx_dv=0, rx_er=1, rx_crs=1 and rxd=1110 for that code group, and the decoder stays outside a frame.
- R4: Outside a frame, every code group other than /J/ gives rx_dv=0, rx_er=0, rx_crs=0 and rxd=0000, and does not open a frame.
- R5: /T/ (01101) directly followed by /R/ (00111) inside a frame closes the frame. Both are presented with rx_dv=0, rx_er=0, rx_crs=0 and rxd=0000.
- R6: Inside a frame, /H/ (00100), any undefined code group, /J/, /K/, /R/, or a /T/ not followed by /R/ gives rx_dv=1, rx_er=1, rx_crs=1 and rxd=0101, and the frame continues.
- R7: IDLE (11111) inside a frame gives rx_dv=0, rx_er=1, rx_crs=0 and rxd=0000 for that code group and closes the frame.
- R8: out_valid is high exactly in the cycle after each accepted code group. The strobe for code group k carries the result for code group k-1. The first strobe after reset carries the result for an implied IDLE. While in_valid is low, all outputs hold.
- R9: During and right after reset, out_valid, rx_dv, rx_er, rx_crs and rxd are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_sym for this cycle |
| in_sym | input | 5 | Aligned 5-bit code group |
| out_valid | output | 1 | Strobe: outputs were updated |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rx_crs | output | 1 | Carrier present |
| rxd | output | 4 | Receive data nibble |

## Verification
End-delimiter look-ahead and error substitution are both decided from the same held /T/ in one cycle. A /T/ followed by /R/ must close the frame quietly, while a /T/ followed by anything else must instead be reported as a bad code group with the frame kept open. The bench sends /T/ then /H/ mid-frame, followed by more data and a bare IDLE. It then checks that the /T/ strobe shows the error nibble rather than a close, and that the later IDLE still reports the abrupt end. The same pairing on the start side is checked with /J/ /J/ /K/, where one strobe must report a false carrier and the next must open a frame.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int SYM_W  = 5;
  localparam int NIB_W  = 4;
  localparam int N_DATA = 1 << NIB_W;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NIB_W-1:0] nib_t;

  localparam sym_t CG_IDLE = 5'b11111;
  localparam sym_t CG_J    = 5'b11000;
  localparam sym_t CG_K    = 5'b10001;
  localparam sym_t CG_T    = 5'b01101;
  localparam sym_t CG_R    = 5'b00111;
  localparam sym_t CG_H    = 5'b00100;

  typedef enum logic [2:0] {
    KD_DATA, KD_IDLE, KD_J, KD_K, KD_T, KD_R, KD_H, KD_BAD
  } kind_t;

  typedef enum logic [1:0] {
    FS_HUNT, FS_PRE_K, FS_FRAME, FS_END_R
  } fstate_t;

  typedef struct packed {
    logic dv;
    logic er;
    logic crs;
    nib_t nib;
  } mii_t;

  // 4B/5B forward mapping: nibble value to its line code group
  function automatic sym_t data_code(input nib_t n);
    sym_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/rxs_sym_hold.sv
module rxs_sym_hold
  import rxs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  sym_t in_sym,
  output sym_t cur_sym,
  output logic nxt_is_k,
  output logic nxt_is_r
);
  // One code group of look-ahead; reset behaves as if IDLE had been held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cur_sym <= CG_IDLE;
    else if (in_valid) cur_sym <= in_sym;
  end

  assign nxt_is_k = (in_sym == CG_K);
  assign nxt_is_r = (in_sym == CG_R);
endmodule

// File: rtl/rxs_sym_class.sv
module rxs_sym_class
  import rxs_pkg::*;
(
  input  sym_t  sym,
  output kind_t kind,
  output nib_t  nib
);
  logic [N_DATA-1:0] hit;

  // One comparator per data code group
  genvar g;
  generate
    for (g = 0; g < N_DATA; g++) begin : g_cmp
      assign hit[g] = (sym == data_code(nib_t'(g)));
    end
  endgenerate

  always_comb begin
    nib = '0;
    for (int i = 0; i < N_DATA; i++) begin
      if (hit[i]) nib = nib | nib_t'(i);
    end
  end

  always_comb begin
    if (|hit) begin
      kind = KD_DATA;
    end else begin
      case (sym)
        CG_IDLE: kind = KD_IDLE;
        CG_J:    kind = KD_J;
        CG_K:    kind = KD_K;
        CG_T:    kind = KD_T;
        CG_R:    kind = KD_R;
        CG_H:    kind = KD_H;
        default: kind = KD_BAD;
      endcase
    end
  end
endmodule

// File: rtl/rxs_framer.sv
module rxs_framer
  import rxs_pkg::*;
#(
  parameter nib_t PRE_NIB = 4'b0101,
  parameter nib_t ERR_NIB = 4'b0101,
  parameter nib_t FC_NIB  = 4'b1110
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  kind_t cur_kind,
  input  nib_t  cur_nib,
  input  logic  nxt_is_k,
  input  logic  nxt_is_r,
  output mii_t  mii_q,
  output logic  out_valid
);
  fstate_t st, nxt_st;
  mii_t    o;

  always_comb begin
    nxt_st = st;
    o      = '0;
    case (st)
      FS_HUNT: begin
        if (cur_kind == KD_J) begin
          o.crs = 1'b1;
          if (nxt_is_k) begin
            o.dv   = 1'b1;
            o.nib  = PRE_NIB;
            nxt_st = FS_PRE_K;
          end else begin
            o.er  = 1'b1;
            o.nib = FC_NIB;
          end
        end
      end
      FS_PRE_K: begin
        o.dv   = 1'b1;
        o.crs  = 1'b1;
        o.nib  = PRE_NIB;
        nxt_st = FS_FRAME;
      end
      FS_FRAME: begin
        case (cur_kind)
          KD_DATA: begin
            o.dv  = 1'b1;
            o.crs = 1'b1;
            o.nib = cur_nib;
          end
          KD_IDLE: begin
            o.er   = 1'b1;
            nxt_st = FS_HUNT;
          end
          KD_T: begin
            if (nxt_is_r) begin
              nxt_st = FS_END_R;
            end else begin
              o.dv  = 1'b1;
              o.er  = 1'b1;
              o.crs = 1'b1;
              o.nib = ERR_NIB;
            end
          end
          default: begin
            o.dv  = 1'b1;
            o.er  = 1'b1;
            o.crs = 1'b1;
            o.nib = ERR_NIB;
          end
        endcase
      end
      default: begin
        nxt_st = FS_HUNT;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FS_HUNT;
      mii_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= adv;
      if (adv) begin
        st    <= nxt_st;
        mii_q <= o;
      end
    end
  end
endmodule

// File: rtl/rxs_decoder.sv
module rxs_decoder
  import rxs_pkg::*;
#(
  parameter nib_t PRE_NIB = 4'b0101,
  parameter nib_t ERR_NIB = 4'b0101,
  parameter nib_t FC_NIB  = 4'b1110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SYM_W-1:0] in_sym,
  output logic             out_valid,
  output logic             rx_dv,
  output logic             rx_er,
  output logic             rx_crs,
  output logic [NIB_W-1:0] rxd
);
  sym_t  cur_sym;
  logic  nxt_is_k, nxt_is_r;
  kind_t cur_kind;
  nib_t  cur_nib;
  mii_t  mii_q;

  rxs_sym_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sym   (in_sym),
    .cur_sym  (cur_sym),
    .nxt_is_k (nxt_is_k),
    .nxt_is_r (nxt_is_r)
  );

  rxs_sym_class u_class (
    .sym  (cur_sym),
    .kind (cur_kind),
    .nib  (cur_nib)
  );

  rxs_framer #(
    .PRE_NIB (PRE_NIB),
    .ERR_NIB (ERR_NIB),
    .FC_NIB  (FC_NIB)
  ) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (in_valid),
    .cur_kind  (cur_kind),
    .cur_nib   (cur_nib),
    .nxt_is_k  (nxt_is_k),
    .nxt_is_r  (nxt_is_r),
    .mii_q     (mii_q),
    .out_valid (out_valid)
  );

  assign rx_dv  = mii_q.dv;
  assign rx_er  = mii_q.er;
  assign rx_crs = mii_q.crs;
  assign rxd    = mii_q.nib;
endmodule

// File: rtl/rxs_decoder_chk.sv
module rxs_decoder_chk
  import rxs_pkg::*;
#(
  parameter nib_t PRE_NIB = 4'b0101,
  parameter nib_t ERR_NIB = 4'b0101,
  parameter nib_t FC_NIB  = 4'b1110
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic             rx_dv,
  input logic             rx_er,
  input logic             rx_crs,
  input logic [NIB_W-1:0] rxd
);
  p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(rx_dv) && $stable(rx_er) &&
                   $stable(rx_crs) && $stable(rxd)));

  p_dv_has_crs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv |-> rx_crs);

  p_open_preamble_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> (rxd == PRE_NIB && !rx_er));

  p_false_carrier_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && !rx_dv && rx_crs) |-> (rxd == FC_NIB));

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_crs && !rx_er) |-> (!rx_dv && rxd == '0));

  p_err_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && rx_er) |-> (rxd == ERR_NIB));

  p_abrupt_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && !rx_crs) |-> (!rx_dv && rxd == '0));

  always_comb begin
    if (!rst_n) begin
      a_reset_r9: assert (!out_valid && !rx_dv && !rx_er && !rx_crs && rxd == '0);
    end
  end
endmodule

bind rxs_decoder rxs_decoder_chk #(
  .PRE_NIB (PRE_NIB),
  .ERR_NIB (ERR_NIB),
  .FC_NIB  (FC_NIB)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .rx_dv     (rx_dv),
  .rx_er     (rx_er),
  .rx_crs    (rx_crs),
  .rxd       (rxd)
);

// File: tb/sim_rxs_decoder.sv
module sim_rxs_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] in_sym = 5'b11111;
  logic       out_valid, rx_dv, rx_er, rx_crs;
  logic [3:0] rxd;

  rxs_decoder u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sym    (in_sym),
    .out_valid (out_valid),
    .rx_dv     (rx_dv),
    .rx_er     (rx_er),
    .rx_crs    (rx_crs),
    .rxd       (rxd)
  );

  always #10 clk = ~clk;

  localparam logic [4:0] S_I = 5'b11111, S_J = 5'b11000, S_K = 5'b10001;
  localparam logic [4:0] S_T = 5'b01101, S_R = 5'b00111, S_H = 5'b00100;
  localparam logic [4:0] S_BAD = 5'b00000;
  localparam logic [4:0] ENC [16] = '{
    5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
    5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};

  // expected {dv, er, crs, rxd}
  localparam logic [6:0] E_QUIET = 7'b000_0000;
  localparam logic [6:0] E_PRE   = 7'b101_0101;
  localparam logic [6:0] E_ERR   = 7'b111_0101;
  localparam logic [6:0] E_FC    = 7'b011_1110;
  localparam logic [6:0] E_CLOSE = 7'b010_0000;

  function automatic logic [6:0] e_data(input logic [3:0] n);
    return {3'b101, n};
  endfunction

  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;
  logic [6:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input string t, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", t, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] s, input logic [6:0] e, input string t);
    @(negedge clk);
    in_valid = 1'b1;
    in_sym   = s;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic gap_hold(input int n);
    logic [6:0] snap;
    @(negedge clk);
    in_valid = 1'b0;
    in_sym   = S_BAD;
    snap = {rx_dv, rx_er, rx_crs, rxd};
    repeat (n) @(negedge clk);
    check("R8 outputs hold in gap", {rx_dv, rx_er, rx_crs, rxd}, snap);
    check("R8 no strobe in gap", {6'b0, out_valid}, 7'b0);
  endtask

  // monitor: scoreboard pop on each output strobe
  always @(negedge clk) begin
    logic [6:0] e;
    string      t;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected strobe", {rx_dv, rx_er, rx_crs, rxd}, 7'bx);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {rx_dv, rx_er, rx_crs, rxd}, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {rx_dv, rx_er, rx_crs, rxd}, E_QUIET);
    check("R9 reset strobe", {6'b0, out_valid}, 7'b0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_q.push_back(E_QUIET);
    tag_q.push_back("R8 implied idle after reset");
    @(negedge clk);
    check("R9 idle after reset", {rx_dv, rx_er, rx_crs, rxd, out_valid} >> 1, E_QUIET);

    // quiet line, then a full frame with every data nibble
    send(S_I, E_QUIET, "R4 idle outside frame");
    send(S_I, E_QUIET, "R4 idle outside frame");
    send(S_J, E_PRE, "R2 J opens");
    send(S_K, E_PRE, "R2 K preamble");
    for (int i = 0; i < 16; i++) send(ENC[i], e_data(4'(i)), "R1 data decode");
    send(S_T, E_QUIET, "R5 T closes");
    send(S_R, E_QUIET, "R5 R closes");
    send(S_I, E_QUIET, "R4 idle after frame");

    // frame with errors, a gap, T not followed by R, and an abrupt idle
    send(S_J, E_PRE, "R2 J opens");
    send(S_K, E_PRE, "R2 K preamble");
    send(ENC[3], e_data(4'h3), "R1 data decode");
    send(S_H, E_ERR, "R6 H in frame");
    send(ENC[10], e_data(4'hA), "R1 data after error");
    gap_hold(3);
    send(S_BAD, E_ERR, "R6 undefined code in frame");
    send(S_T, E_ERR, "R6 T without R");
    send(S_H, E_ERR, "R6 H after lone T");
    send(ENC[7], e_data(4'h7), "R6 frame continues");
    send(S_I, E_CLOSE, "R7 idle in frame");
    send(S_I, E_QUIET, "R7 frame closed");
    send(ENC[5], E_QUIET, "R7 data after close ignored");

    // false carriers
    send(S_J, E_FC, "R3 J then idle");
    send(S_I, E_QUIET, "R4 idle after false carrier");
    send(ENC[5], E_QUIET, "R3 no frame after false carrier");
    send(S_K, E_QUIET, "R4 lone K outside frame");
    send(S_J, E_FC, "R3 J then J");
    send(S_J, E_PRE, "R2 second J opens");
    send(S_K, E_PRE, "R2 K preamble");
    send(ENC[9], e_data(4'h9), "R1 data decode");
    send(S_T, E_QUIET, "R5 T closes");
    send(S_R, E_QUIET, "R5 R closes");

    // back-to-back frame right after R
    send(S_J, E_PRE, "R2 J right after R");
    send(S_K, E_PRE, "R2 K preamble");
    send(ENC[12], e_data(4'hC), "R1 data decode");
    send(S_T, E_QUIET, "R5 T closes");
    send(S_R, E_QUIET, "R5 R closes");
    send(S_I, E_QUIET, "R4 idle after frame");
    send(S_I, E_QUIET, "R4 idle flush");

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 one result still held back", 7'(exp_q.size()), 7'd1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule